// File: doc/BRIEF.md
# Truth-Table Bit-Slice ALU with Steered Carry

This block is an arithmetic and logic unit with no dedicated adder, gate array or shifter per operation. Every bit position is an identical slice. Four shared feed lines act as a two-input truth table. Each slice reads that table at the entry picked by its own pair of operand bits, and the value it reads is the half-sum. The slice result is the half-sum combined with the slice's carry-in. The carry-out is steered by the half-sum: it takes the slice's y bit when the half-sum is low, and it passes the carry-in through when the half-sum is high.

A handful of extra control lines change how the carries and the output are used:
- One line injects a carry at bit 0.
- One line forces every carry-in high, which turns the slices into pure logic.
- One line routes the word through a right shifter.
- One line makes the shifts wrap around.
- One line forces the least significant output bit high.

The controls arrive as a raw 9-bit word. They are not decoded from an opcode.

The result and the final carry-out are captured in an output register when the load strobe is high. A zero flag is captured in the same cycle. The captured value can then be written back to a source register while new operands are applied. The register also hides any glitches that appear while the ripple path settles.

Top module: `mux_alu`

## Requirements
- R1: The half-sum of bit i is ctl[1 + 2*x[i] + y[i]]. So ctl[1] serves operand pair (0,0), ctl[2] serves (0,1), ctl[3] serves (1,0) and ctl[4] serves (1,1).
- R2: Each slice outputs half-sum XOR carry-in. Its carry-out is y[i] when the half-sum is 0 and the carry-in when the half-sum is 1. Carries ripple from bit 0 towards the MSB.
- R3: ctl[0] sets the carry-in of bit 0. ctl = 9'h00C yields x + y with the carry-out as bit WIDTH. ctl = 9'h00D yields x + y + 1. ctl = 9'h013 yields y - x modulo 2^WIDTH.
- R4: ctl[5] forces every slice carry-in to 1, so each result bit is the inverted half-sum. ctl = 9'h02E yields x AND y, and ctl = 9'h022 yields x OR y.
- R5: When ctl[6] is set, output bit i takes slice result i+1. The MSB is filled with 0 unless ctl[7] is set.
- R6: When ctl[7] and ctl[6] are set, the MSB takes slice result 0. When ctl[7] is set and ctl[6] is clear, bit 0's carry-in is additionally ORed with the MSB carry-out of a preliminary pass. That pass uses ctl[0] as the bit-0 carry-in. So ctl = 9'h080 rotates y left by one.
- R7: ctl[8] forces result bit 0 to 1, and this is applied after any shifting.
- R8: On a clock edge with load high, the result and the MSB carry-out of the main pass are captured. With load low, result, carry and zero flag all hold their values.
- R9: The zero flag is captured with the result. It is 1 exactly when the captured result is all zeros.
- R10: Synchronous active-high reset sets the result to 0, the carry to 0 and the zero flag to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Capture strobe for result, carry and zero flag |
| x | input | WIDTH | First operand |
| y | input | WIDTH | Second operand, also the steered carry source |
| ctl | input | 9 | Raw control word; bit k is control line k |
| result | output | WIDTH | Captured result |
| carry_out | output | 1 | Captured MSB carry-out |
| zero | output | 1 | Captured zero flag |

## Verification
The assertions assume the following about the inputs:
- x, y, ctl and load carry known values at every rising edge.
- The captured value depends only on the inputs sampled at the previous edge.

The stimulus meets these assumptions as follows:
- It changes inputs only at falling edges and never leaves them undriven.
- It uses one load-high edge per vector, so each arithmetic property sees exactly one prior operand set.

The sweep runs a 4-bit instance through all 512 control words and all 256 operand pairs. Each vector is compared against a bitwise model of the requirements, and named operations are also compared against plain arithmetic.

// File: rtl/mux_alu_pkg.sv
package mux_alu_pkg;

    localparam int CTL_W = 9;

    typedef struct packed {
        logic       force_lsb;   // control line 8
        logic       wrap;        // control line 7
        logic       shr;         // control line 6
        logic       all_carry;   // control line 5
        logic [3:0] feed;        // control lines 4..1, feed[0] is line 1
        logic       inc;         // control line 0
    } ctl_t;

    localparam logic [CTL_W-1:0] OP_ADD   = 9'h00C;
    localparam logic [CTL_W-1:0] OP_ADD1  = 9'h00D;
    localparam logic [CTL_W-1:0] OP_YSUBX = 9'h013;
    localparam logic [CTL_W-1:0] OP_AND   = 9'h02E;
    localparam logic [CTL_W-1:0] OP_OR    = 9'h022;

    function automatic logic feed_pick(input logic [3:0] feed, input logic xb, input logic yb);
        return feed[{xb, yb}];
    endfunction

endpackage

// File: rtl/mux_alu_feed.sv
module mux_alu_feed
    import mux_alu_pkg::*;
#(
    parameter int WIDTH = 10
) (
    input  logic [3:0]       feed,
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    output logic [WIDTH-1:0] half
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        assign half[i] = feed_pick(feed, x[i], y[i]);
    end

endmodule

// File: rtl/mux_alu_chain.sv
module mux_alu_chain #(
    parameter int WIDTH = 10
) (
    input  logic [WIDTH-1:0] half,
    input  logic [WIDTH-1:0] y,
    input  logic             inc,
    input  logic             all_carry,
    input  logic             wrap_left,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);

    logic wrap_bit;

    // preliminary pass: yields the MSB carry that a left rotation feeds back
    always_comb begin
        logic c;
        logic ci;
        c = inc;
        for (int i = 0; i < WIDTH; i++) begin
            ci = all_carry | c;
            c  = half[i] ? ci : y[i];
        end
        wrap_bit = c;
    end

    // main pass
    always_comb begin
        logic c;
        logic ci;
        c = inc | (wrap_left & wrap_bit);
        for (int i = 0; i < WIDTH; i++) begin
            ci     = all_carry | c;
            sum[i] = half[i] ^ ci;
            c      = half[i] ? ci : y[i];
        end
        cout = c;
    end

endmodule

// File: rtl/mux_alu_shift.sv
module mux_alu_shift #(
    parameter int WIDTH = 10
) (
    input  logic [WIDTH-1:0] sum,
    input  logic             shr,
    input  logic             wrap,
    input  logic             force_lsb,
    output logic [WIDTH-1:0] out
);

    always_comb begin
        if (shr) out = {wrap & sum[0], sum[WIDTH-1:1]};
        else     out = sum;
        if (force_lsb) out[0] = 1'b1;
    end

endmodule

// File: rtl/mux_alu.sv
module mux_alu
    import mux_alu_pkg::*;
#(
    parameter int WIDTH = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [WIDTH-1:0]     x,
    input  logic [WIDTH-1:0]     y,
    input  logic [CTL_W-1:0]     ctl,
    output logic [WIDTH-1:0]     result,
    output logic                 carry_out,
    output logic                 zero
);

    ctl_t             c;
    logic [WIDTH-1:0] half;
    logic [WIDTH-1:0] sum;
    logic [WIDTH-1:0] shaped;
    logic             cout;
    logic [WIDTH-1:0] res_q;
    logic             cy_q;
    logic             zf_q;

    assign c = ctl_t'(ctl);

    mux_alu_feed #(.WIDTH(WIDTH)) u_feed (
        .feed (c.feed),
        .x    (x),
        .y    (y),
        .half (half)
    );

    mux_alu_chain #(.WIDTH(WIDTH)) u_chain (
        .half      (half),
        .y         (y),
        .inc       (c.inc),
        .all_carry (c.all_carry),
        .wrap_left (c.wrap & ~c.shr),
        .sum       (sum),
        .cout      (cout)
    );

    mux_alu_shift #(.WIDTH(WIDTH)) u_shift (
        .sum       (sum),
        .shr       (c.shr),
        .wrap      (c.wrap),
        .force_lsb (c.force_lsb),
        .out       (shaped)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            cy_q  <= 1'b0;
            zf_q  <= 1'b1;
        end else if (load) begin
            res_q <= shaped;
            cy_q  <= cout;
            zf_q  <= (shaped == '0);
        end
    end

    assign result    = res_q;
    assign carry_out = cy_q;
    assign zero      = zf_q;

    assert_zero_flag_R9: assert property (@(posedge clk) disable iff (rst)
        zero == (result == '0));

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(load)) |-> ($stable(result) && $stable(carry_out) && $stable(zero)));

    assert_force_lsb_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(load) && $past(ctl[8])) |-> result[0]);

    assert_shr_fill_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(load) && $past(ctl[6]) && !$past(ctl[7]) && !(WIDTH == 1 && $past(ctl[8])))
        |-> !result[WIDTH-1]);

    assert_add_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(load) && $past(ctl) == OP_ADD)
        |-> ({carry_out, result} == ({1'b0, $past(x)} + {1'b0, $past(y)})));

    assert_and_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(load) && $past(ctl) == OP_AND)
        |-> (result == ($past(x) & $past(y))));

endmodule

// File: tb/sim_mux_alu.sv
module sim_mux_alu;

    localparam int W = 4;
    localparam logic [W-1:0] MASK = '1;

    logic         clk = 1'b0;
    logic         rst;
    logic         load;
    logic [W-1:0] x;
    logic [W-1:0] y;
    logic [8:0]   ctl;
    logic [W-1:0] result;
    logic         carry_out;
    logic         zero;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    mux_alu #(.WIDTH(W)) u0 (
        .clk(clk), .rst(rst), .load(load), .x(x), .y(y), .ctl(ctl),
        .result(result), .carry_out(carry_out), .zero(zero)
    );

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual cycles=%0d expected < 190000", cycles);
            finish_run();
        end
    end

    task automatic check(input string req, input logic [W+1:0] act, input logic [W+1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h (ctl=%h x=%h y=%h)", req, act, exp, ctl, x, y);
        end
    endtask

    // bitwise reference derived from the requirements; returns {zero, carry, result}
    function automatic logic [W+1:0] model(input logic [8:0] k, input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] h, s, o;
        logic c, ci, wr;
        for (int i = 0; i < W; i++) h[i] = k[1 + 2*a[i] + b[i]];
        c = k[0];
        for (int i = 0; i < W; i++) begin
            ci = k[5] | c;
            c  = h[i] ? ci : b[i];
        end
        wr = c;
        c  = k[0] | (k[7] & ~k[6] & wr);
        for (int i = 0; i < W; i++) begin
            ci   = k[5] | c;
            s[i] = h[i] ^ ci;
            c    = h[i] ? ci : b[i];
        end
        o = s;
        if (k[6]) begin
            for (int i = 0; i < W-1; i++) o[i] = s[i+1];
            o[W-1] = k[7] ? s[0] : 1'b0;
        end
        if (k[8]) o[0] = 1'b1;
        return {(o == '0), c, o};
    endfunction

    task automatic apply(input logic [8:0] k, input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        ctl = k; x = a; y = b; load = 1'b1;
        @(posedge clk);
        #2;
    endtask

    initial begin
        rst = 1'b1; load = 1'b0; x = '0; y = '0; ctl = '0;
        repeat (3) @(posedge clk);
        #2;
        check("R10 reset", {zero, carry_out, result}, {1'b1, 1'b0, {W{1'b0}}});
        @(negedge clk);
        rst = 1'b0;

        for (int k = 0; k < 512; k++) begin
            for (int v = 0; v < 256; v++) begin
                logic [W-1:0] a, b;
                logic [W+1:0] e;
                a = v[7:4];
                b = v[3:0];
                apply(k[8:0], a, b);
                e = model(k[8:0], a, b);
                check("R1 R2 R5 R6 R7 R8 R9 model", {zero, carry_out, result}, e);
                case (k)
                    12'h00C: check("R3 add", {2'b00, carry_out, result}, {2'b00, ({1'b0, a} + {1'b0, b})});
                    12'h00D: check("R3 add plus one", {2'b00, carry_out, result}, {2'b00, ({1'b0, a} + {1'b0, b} + 5'd1)});
                    12'h013: check("R3 y minus x", {2'b00, result}, {2'b00, (b - a) & MASK});
                    12'h02E: check("R4 and", {2'b00, result}, {2'b00, a & b});
                    12'h022: check("R4 or", {2'b00, result}, {2'b00, a | b});
                    12'h06A: check("R5 shift right", {2'b00, result}, {2'b00, b >> 1});
                    12'h0EA: check("R6 rotate right", {2'b00, result}, {2'b00, {b[0], b[W-1:1]}});
                    12'h080: check("R6 rotate left", {2'b00, result}, {2'b00, {b[W-2:0], b[W-1]}});
                    12'h100: check("R7 force lsb", {2'b00, result}, {2'b00, ((b << 1) | 4'd1) & MASK});
                    default: ;
                endcase
            end
        end

        // R8: load low, operands and controls change, outputs must hold
        apply(9'h00C, 4'h9, 4'h9);
        @(negedge clk);
        load = 1'b0; ctl = 9'h022; x = 4'h0; y = 4'h0;
        repeat (3) @(posedge clk);
        #2;
        check("R8 hold", {zero, carry_out, result}, {1'b0, 1'b1, 4'h2});

        // R9: load a zero result
        apply(9'h02E, 4'h5, 4'hA);
        check("R9 zero flag", {zero, carry_out, result}, {1'b1, model(9'h02E, 4'h5, 4'hA)});

        finish_run();
    end

endmodule